// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers 64 interrupt request lines from around the chip and presents them to a processor as one interrupt output plus a vector the handler can read. Each line is set up on its own: it can be sensitive to a level or to a rising edge, and it carries a 4-bit priority. Software unmasks lines by writing ones to an enable register and masks them by writing ones to a disable register. Lines 0 to 31 are handled through one pair of registers and lines 32 to 63 through a second pair. A global generation enable gates the output. A soft reset register returns all configuration to zero.

When the handler reads the vector register, the returned source's priority is marked as in service. From then on only requests of strictly higher priority raise the output, until an end-of-interrupt write retires the highest in-service level. All request lines pass through a synchronizer before they are used. Registers are reached through a plain single-cycle port. Reads return data in the same cycle, and writes take effect at the next clock edge.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After the reset input is released, every source is masked, generation is off, every setup register reads 0, the vector register reads 64 and the interrupt output is low.
- R2: A write to byte offset 0x010 unmasks the sources 0-31 whose bits are 1, and a write to 0x018 does the same for sources 32-63 (bit i is source 32+i). Zero bits leave a source's mask unchanged. Reading either offset returns that bank's enable bits.
- R3: A write to 0x020 masks the sources 0-31 whose bits are 1, and a write to 0x028 masks sources 32-63. Zero bits change nothing. Reading 0x020 or 0x028 returns the same bank's enable bits.
- R4: Source n has a setup register at byte offset 0x200 + 8*n. Bit 8 selects edge mode (1) or level mode (0), and bits 3:0 hold the priority. Reading the register returns exactly these fields.
- R5: A level-mode source is pending while its synchronized line is high, and stops being pending when the line falls.
- R6: An edge-mode source latches pending on a rising edge of its line and stays pending after the line falls. The latch clears when the setup register is written with bit 8 at 0; writing bit 8 back to 1 does not set it again.
- R7: The vector register (offset 0x030) returns the number of the enabled pending source with the highest priority. On equal priority the lowest source number wins. Masked sources never take part.
- R8: The vector register reads 64 when no enabled pending source can be presented.
- R9: Bit 0 of offset 0x008 is the generation enable. While it is 0 the interrupt output stays low; while it is 1 the output is high exactly when a source can be presented.
- R10: A vector read that returns a source below 64 marks that source's priority as in service. Afterwards only a request of strictly higher priority than the highest in-service level raises the output or appears in the vector.
- R11: Any write to offset 0x038 retires the highest in-service priority level, whatever data is written. The next lower in-service level, or none, then sets the threshold.
- R12: Writing 1 to bit 0 of offset 0x000 clears the masks, the setup registers, the generation enable, the edge latches and the in-service state at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | 64 | Asynchronous interrupt request lines, one per source |
| reg_addr | input | 10 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_rd | input | 1 | Read strobe; a vector read takes effect at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, valid in the same cycle |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Priority selection is tried with pairs of level sources placed in both banks. In some pairs the higher source number has the higher priority, in others the lower number does, some pairs tie (including two sources at the extreme ends of the range) and one pair sits at priority 0. Together these separate a pure priority compare, a pure index order and the tie-break. Edge sources are pulsed and then checked after the line falls and again after the mode toggle, which separates latching from level following. A nested sequence of a low and a high priority source, with end-of-interrupt writes carrying nonzero data, shows the in-service threshold rising and then dropping level by level.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_SRST  = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_GEN   = 10'h008;
  localparam logic [ADDR_W-1:0] OFF_ENLO  = 10'h010;
  localparam logic [ADDR_W-1:0] OFF_ENHI  = 10'h018;
  localparam logic [ADDR_W-1:0] OFF_DSLO  = 10'h020;
  localparam logic [ADDR_W-1:0] OFF_DSHI  = 10'h028;
  localparam logic [ADDR_W-1:0] OFF_VEC   = 10'h030;
  localparam logic [ADDR_W-1:0] OFF_EOI   = 10'h038;

  localparam int unsigned SETUP_SEL_BIT = 9;
  localparam int unsigned SETUP_EDGE_BIT = 8;
endpackage

// File: rtl/irq_vc_capture.sv
module irq_vc_capture #(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [N_SRC-1:0] raw,
  input  logic [N_SRC-1:0] edge_mode,
  output logic [N_SRC-1:0] pending
);
  logic [N_SRC-1:0] sync_q [STAGES];
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] lat_q, lat_d;
  logic [N_SRC-1:0] line_s;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= '0;
        else        sync_q[g] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= '0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign line_s = sync_q[STAGES-1];

  always_comb begin
    if (clr) lat_d = '0;
    else     lat_d = (lat_q | (line_s & ~prev_q)) & edge_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= line_s;
      lat_q  <= lat_d;
    end
  end

  assign pending = (edge_mode & lat_q) | (~edge_mode & line_s);
endmodule

// File: rtl/irq_vc_select.sv
module irq_vc_select #(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]  cand,
  input  logic [PRIO_W-1:0] prio [N_SRC],
  output logic              valid,
  output logic [IDX_W-1:0]  idx,
  output logic [PRIO_W-1:0] best
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i] && (!valid || prio[i] >= best)) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
        best  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_vc_service.sv
module irq_vc_service #(
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned LVLS = 1 << PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [PRIO_W-1:0] take_prio,
  input  logic              done,
  output logic              busy,
  output logic [PRIO_W-1:0] top,
  output logic [LVLS-1:0]   map
);
  logic [LVLS-1:0] map_d;

  always_comb begin
    busy = 1'b0;
    top  = '0;
    for (int l = 0; l < LVLS; l++) begin
      if (map[l]) begin
        busy = 1'b1;
        top  = PRIO_W'(l);
      end
    end
  end

  always_comb begin
    map_d = map;
    if (done && busy) map_d[top] = 1'b0;
    if (take)         map_d[take_prio] = 1'b1;
    if (clr)          map_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map <= '0;
    else        map <= map_d;
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vc_pkg::*;
#(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_lines,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  localparam int unsigned BANK  = 32;
  localparam int unsigned IDX_W = $clog2(N_SRC);
  localparam int unsigned VEC_W = IDX_W + 1;
  localparam int unsigned LVLS  = 1 << PRIO_W;
  localparam logic [VEC_W-1:0] VEC_NONE = VEC_W'(N_SRC);

  // reset: async assert, sync release
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // configuration state
  logic [N_SRC-1:0]  mask_q, mask_d;
  logic [N_SRC-1:0]  edge_q, edge_d;
  logic [PRIO_W-1:0] prio_q [N_SRC];
  logic [PRIO_W-1:0] prio_d [N_SRC];
  logic              gen_q, gen_d;

  logic              soft_rst, eoi_wr, vec_rd, setup_hit;
  logic [IDX_W-1:0]  setup_idx;
  logic [N_SRC-1:0]  pending, cand;
  logic              sel_valid, present;
  logic [IDX_W-1:0]  sel_idx;
  logic [PRIO_W-1:0] sel_prio;
  logic              svc_busy, take;
  logic [PRIO_W-1:0] svc_top;
  logic [LVLS-1:0]   svc_map;
  logic [VEC_W-1:0]  vec_num;

  assign soft_rst  = reg_wr && (reg_addr == OFF_SRST) && reg_wdata[0];
  assign eoi_wr    = reg_wr && (reg_addr == OFF_EOI);
  assign vec_rd    = reg_rd && (reg_addr == OFF_VEC);
  assign setup_hit = reg_addr[SETUP_SEL_BIT];
  assign setup_idx = reg_addr[IDX_W+2:3];

  always_comb begin
    mask_d = mask_q;
    edge_d = edge_q;
    gen_d  = gen_q;
    for (int i = 0; i < N_SRC; i++) prio_d[i] = prio_q[i];
    if (reg_wr) begin
      if (setup_hit) begin
        edge_d[setup_idx] = reg_wdata[SETUP_EDGE_BIT];
        prio_d[setup_idx] = reg_wdata[PRIO_W-1:0];
      end else begin
        case (reg_addr)
          OFF_GEN:  gen_d = reg_wdata[0];
          OFF_ENLO: mask_d[BANK-1:0]     = mask_q[BANK-1:0] | reg_wdata;
          OFF_ENHI: mask_d[N_SRC-1:BANK] = mask_q[N_SRC-1:BANK] | reg_wdata;
          OFF_DSLO: mask_d[BANK-1:0]     = mask_q[BANK-1:0] & ~reg_wdata;
          OFF_DSHI: mask_d[N_SRC-1:BANK] = mask_q[N_SRC-1:BANK] & ~reg_wdata;
          default: ;
        endcase
      end
    end
    if (soft_rst) begin
      mask_d = '0;
      edge_d = '0;
      gen_d  = 1'b0;
      for (int i = 0; i < N_SRC; i++) prio_d[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mask_q <= '0;
      edge_q <= '0;
      gen_q  <= 1'b0;
      for (int i = 0; i < N_SRC; i++) prio_q[i] <= '0;
    end else begin
      mask_q <= mask_d;
      edge_q <= edge_d;
      gen_q  <= gen_d;
      for (int i = 0; i < N_SRC; i++) prio_q[i] <= prio_d[i];
    end
  end

  irq_vc_capture #(.N_SRC(N_SRC), .STAGES(STAGES)) u_capture (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (soft_rst),
    .raw       (irq_lines),
    .edge_mode (edge_q),
    .pending   (pending)
  );

  assign cand = pending & mask_q;

  irq_vc_select #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_select (
    .cand  (cand),
    .prio  (prio_q),
    .valid (sel_valid),
    .idx   (sel_idx),
    .best  (sel_prio)
  );

  assign present = sel_valid && (!svc_busy || (sel_prio > svc_top));
  assign vec_num = present ? {1'b0, sel_idx} : VEC_NONE;
  assign take    = vec_rd && present && !soft_rst;

  irq_vc_service #(.PRIO_W(PRIO_W)) u_service (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (soft_rst),
    .take      (take),
    .take_prio (sel_prio),
    .done      (eoi_wr),
    .busy      (svc_busy),
    .top       (svc_top),
    .map       (svc_map)
  );

  assign irq_out = gen_q && present;

  always_comb begin
    reg_rdata = '0;
    if (setup_hit) begin
      reg_rdata[PRIO_W-1:0]     = prio_q[setup_idx];
      reg_rdata[SETUP_EDGE_BIT] = edge_q[setup_idx];
    end else begin
      case (reg_addr)
        OFF_GEN:            reg_rdata[0] = gen_q;
        OFF_ENLO, OFF_DSLO: reg_rdata = mask_q[BANK-1:0];
        OFF_ENHI, OFF_DSHI: reg_rdata = mask_q[N_SRC-1:BANK];
        OFF_VEC:            reg_rdata = DATA_W'(vec_num);
        default:            reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
  import irq_vc_pkg::*;
#(
  parameter int unsigned N_SRC = 64,
  parameter int unsigned VEC_W = 7,
  parameter int unsigned LVLS  = 16
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              soft_rst,
  input logic              gen_q,
  input logic              irq_out,
  input logic [VEC_W-1:0]  vec_num,
  input logic              vec_rd,
  input logic              eoi_wr,
  input logic [LVLS-1:0]   svc_map,
  input logic [N_SRC-1:0]  mask_q,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata
);
  logic wr_enlo, wr_dslo;
  assign wr_enlo = reg_wr && (reg_addr == OFF_ENLO);
  assign wr_dslo = reg_wr && (reg_addr == OFF_DSLO);

  assert_soft_clear_R12: assert property (@(posedge clk) disable iff (!rst_int_n)
    soft_rst |=> (!irq_out && !gen_q && mask_q == '0 && svc_map == '0));

  assert_gen_gate_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !gen_q |-> !irq_out);

  assert_vec_range_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_out |-> (vec_num < VEC_W'(N_SRC)));

  assert_take_marks_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (vec_rd && vec_num < VEC_W'(N_SRC) && !soft_rst && !eoi_wr) |=> (svc_map != '0));

  assert_eoi_retire_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (eoi_wr && svc_map != '0 && !vec_rd && !soft_rst)
      |=> ($countones(svc_map) == $countones($past(svc_map)) - 1));

  assert_enable_or_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_enlo |=> (mask_q[31:0] == ($past(mask_q[31:0]) | $past(reg_wdata))));

  assert_disable_and_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_dslo |=> (mask_q[31:0] == ($past(mask_q[31:0]) & ~$past(reg_wdata))));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W), .LVLS(LVLS)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .soft_rst  (soft_rst),
  .gen_q     (gen_q),
  .irq_out   (irq_out),
  .vec_num   (vec_num),
  .vec_rd    (vec_rd),
  .eoi_wr    (eoi_wr),
  .svc_map   (svc_map),
  .mask_q    (mask_q),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata)
);

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq_lines;
  logic [9:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rv;

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  localparam logic [9:0] A_SRST = 10'h000, A_GEN = 10'h008, A_ENLO = 10'h010,
    A_ENHI = 10'h018, A_DSLO = 10'h020, A_DSHI = 10'h028, A_VEC = 10'h030,
    A_EOI = 10'h038;

  // vector: {src_a[6], prio_a[4], src_b[6], prio_b[4], expected[7]}
  localparam int NV = 6;
  localparam logic [26:0] VTAB [NV] = '{
    {6'd5,  4'd3,  6'd40, 4'd7,  7'd40},
    {6'd5,  4'd9,  6'd40, 4'd7,  7'd5},
    {6'd12, 4'd4,  6'd3,  4'd4,  7'd3},
    {6'd63, 4'd15, 6'd0,  4'd15, 7'd0},
    {6'd33, 4'd1,  6'd32, 4'd1,  7'd32},
    {6'd10, 4'd0,  6'd20, 4'd0,  7'd10}
  };

  function automatic logic [9:0] saddr(input int s);
    return 10'(512 + s * 8);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic enable_src(input int s);
    if (s < 32) wr(A_ENLO, 32'd1 << s);
    else        wr(A_ENHI, 32'd1 << (s - 32));
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_lines = '0; reg_addr = '0; reg_wr = 1'b0;
    reg_rd = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    chk("R1 irq_out", 32'(irq_out), 32'd0);
    rd(A_ENLO, rv); chk("R1 mask lo", rv, 32'd0);
    rd(A_ENHI, rv); chk("R1 mask hi", rv, 32'd0);
    rd(A_GEN, rv);  chk("R1 gen", rv, 32'd0);
    rd(saddr(5), rv); chk("R1 setup", rv, 32'd0);
    rd(A_VEC, rv);  chk("R1 vector", rv, 32'd64);

    // R2 / R3 enable and disable banks
    wr(A_ENLO, 32'h0000_00F0);
    wr(A_ENHI, 32'h8000_0001);
    rd(A_ENLO, rv); chk("R2 en lo", rv, 32'h0000_00F0);
    rd(A_ENHI, rv); chk("R2 en hi", rv, 32'h8000_0001);
    wr(A_ENLO, 32'h0000_000F);
    rd(A_ENLO, rv); chk("R2 zeros keep", rv, 32'h0000_00FF);
    wr(A_DSLO, 32'h0000_0030);
    rd(A_DSLO, rv); chk("R3 dis lo", rv, 32'h0000_00CF);
    wr(A_DSHI, 32'h0000_0001);
    rd(A_DSHI, rv); chk("R3 dis hi", rv, 32'h8000_0000);

    // R4 setup readback
    wr(saddr(63), 32'h0000_010B);
    rd(saddr(63), rv); chk("R4 setup 63", rv, 32'h0000_010B);
    wr(saddr(1), 32'hFFFF_FE06);
    rd(saddr(1), rv); chk("R4 setup 1 fields", rv, 32'h0000_0006);

    // R12 soft reset
    wr(A_GEN, 32'd1);
    wr(A_SRST, 32'd1);
    rd(A_ENLO, rv); chk("R12 mask", rv, 32'd0);
    rd(saddr(63), rv); chk("R12 setup", rv, 32'd0);
    rd(A_GEN, rv); chk("R12 gen", rv, 32'd0);

    // R7 priority table
    for (int k = 0; k < NV; k++) begin
      int sa, sb;
      logic [26:0] e;
      e = VTAB[k];
      sa = int'(e[26:21]); sb = int'(e[16:11]);
      irq_lines = '0;
      wr(A_SRST, 32'd1);
      settle();
      wr(A_GEN, 32'd1);
      wr(saddr(sa), 32'(e[20:17]));
      wr(saddr(sb), 32'(e[10:7]));
      enable_src(sa);
      enable_src(sb);
      irq_lines[sa] = 1'b1;
      irq_lines[sb] = 1'b1;
      settle();
      chk($sformatf("R7 irq_out row %0d", k), 32'(irq_out), 32'd1);
      rd(A_VEC, rv); chk($sformatf("R7 vector row %0d", k), rv, 32'(e[6:0]));
    end

    // R5 level follows line; masked source ignored (R7, R8)
    irq_lines = '0;
    wr(A_SRST, 32'd1);
    settle();
    wr(A_GEN, 32'd1);
    wr(saddr(3), 32'd1);
    irq_lines[3] = 1'b1;
    settle();
    chk("R7 masked ignored", 32'(irq_out), 32'd0);
    rd(A_VEC, rv); chk("R8 none vector", rv, 32'd64);
    enable_src(3);
    settle();
    chk("R5 level high", 32'(irq_out), 32'd1);
    irq_lines[3] = 1'b0;
    settle();
    chk("R5 level low", 32'(irq_out), 32'd0);

    // R9 generation gate
    irq_lines[3] = 1'b1;
    wr(A_GEN, 32'd0);
    settle();
    chk("R9 gen off", 32'(irq_out), 32'd0);
    wr(A_GEN, 32'd1);
    chk("R9 gen on", 32'(irq_out), 32'd1);
    irq_lines[3] = 1'b0;
    wr(A_DSLO, 32'd1 << 3);

    // R6 edge latch
    wr(saddr(20), 32'h0000_0102);
    enable_src(20);
    settle();
    chk("R6 no edge yet", 32'(irq_out), 32'd0);
    irq_lines[20] = 1'b1;
    settle();
    irq_lines[20] = 1'b0;
    settle();
    chk("R6 latched after fall", 32'(irq_out), 32'd1);
    wr(saddr(20), 32'h0000_0002);
    wr(saddr(20), 32'h0000_0102);
    settle();
    chk("R6 cleared by toggle", 32'(irq_out), 32'd0);
    rd(A_VEC, rv); chk("R6 vector after clear", rv, 32'd64);

    // R10 / R11 in service and end of interrupt
    irq_lines = '0;
    wr(A_SRST, 32'd1);
    settle();
    wr(A_GEN, 32'd1);
    wr(saddr(7), 32'd5);
    wr(saddr(50), 32'd9);
    enable_src(7);
    enable_src(50);
    irq_lines[7] = 1'b1;
    settle();
    rd(A_VEC, rv); chk("R10 take low", rv, 32'd7);
    chk("R10 same level held", 32'(irq_out), 32'd0);
    rd(A_VEC, rv); chk("R10 same level vector", rv, 32'd64);
    irq_lines[50] = 1'b1;
    settle();
    chk("R10 higher presented", 32'(irq_out), 32'd1);
    rd(A_VEC, rv); chk("R10 take high", rv, 32'd50);
    chk("R10 nested held", 32'(irq_out), 32'd0);
    wr(A_EOI, 32'hDEAD_BEEF);
    chk("R11 retire top", 32'(irq_out), 32'd1);
    rd(A_VEC, rv); chk("R11 vector after eoi", rv, 32'd50);
    irq_lines[50] = 1'b0;
    wr(A_EOI, 32'h0000_0000);
    wr(A_EOI, 32'h1234_5678);
    settle();
    chk("R11 low level free", 32'(irq_out), 32'd1);
    rd(A_VEC, rv); chk("R11 low vector", rv, 32'd7);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule